// File: doc/BRIEF.md
# Staged Clock Divider Ratio Controller

This block produces a set of divided clock enables from one reference clock. Each output has its own programmable divide ratio. Software changes a ratio through a small register bus. A new ratio does not take effect when it is written. It is held as pending, and a per-output change flag records that it differs from the ratio in use.

A GO command, issued by writing a self-clearing control bit, commits the pending ratios. Only outputs whose flag is set get a new ratio; outputs with a clear flag keep their ratio. The commit takes one hold cycle. During that cycle every divider counter is parked and every enable is low. At the end of it all counters restart together, so every output's enable fires on the same reference edge and the outputs stay phase-aligned.

The block has no data stream. Both the register bus and the enables are plain control pins with no back-pressure. A bus write takes effect on the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. Register map: address n (for n below NUM_OUT) holds the ratio of output n. Address NUM_OUT is control, and address NUM_OUT+1 is the change status.

Top module: `staged_clkdiv_ctrl`

## Requirements
- R1: After reset every ratio register reads 0 (divide-by-1), the status and control registers read 0, and every `div_en` bit is high on every cycle.
- R2: Writing a ratio value (bits 4:0) that differs from the active ratio of output n sets status bit 3+n: bit 3 for output 0 and bit 4 for output 1. Reading the ratio address returns the last written (pending) value.
- R3: Writing a ratio equal to the active ratio leaves that output's status flag clear after the write, including a flag that was set before.
- R4: A ratio write does not change any enable pattern until a GO commits it.
- R5: Writing 1 to control bit 0 while any flag is set starts a single hold cycle. In that cycle control bit 1 (busy) reads 1 and every `div_en` bit is low.
- R6: In the first cycle after the hold cycle, every `div_en` bit is high. From then on, output n's enable is high exactly in the cycles k (counted from 0 at that cycle) where k mod (ratio_n+1) is 0.
- R7: When the hold cycle ends, flagged outputs take their pending ratio, unflagged outputs keep their ratio, all flags read 0, and busy reads 0.
- R8: GO writes and ratio writes issued while busy is high are ignored.
- R9: A GO write while no flag is set has no effect: busy stays 0 and no enable pattern is interrupted.
- R10: The status register is read-only and its bits other than the flag bits read 0. Control bit 0 always reads 0.
- R11: A ratio value v divides by v+1: once settled, output n's enable is high for one cycle in every v+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| div_en | output | NUM_OUT | One-cycle clock enables, one bit per divided output |

## Verification
Every cycle, the enables are compared with a model of ratios and phase that is built from the requirements. Any drift in period, phase or hold timing therefore shows up at once. The directed part covers several cases: a changed ratio against an unchanged one (R2, R3), a write-back of the active value that cancels a flag, and a ratio write in the middle of a period that must not disturb the running pattern (R4). It also issues a GO with nothing flagged and bus traffic during the hold cycle, which separate a committing design from one that ignores commands correctly. Seeded random writes, GO commands and reads, with ratios sometimes equal to the active value, mix these events in orders the directed cases do not reach.

// File: rtl/stg_div_pkg.sv
package stg_div_pkg;
  localparam int FLAG_LSB = 3;
  localparam int GO_BIT   = 0;
  localparam int BUSY_BIT = 1;

  typedef enum logic [1:0] {
    SEL_RATIO  = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stg_regs.sv
module stg_regs
  import stg_div_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int RATIO_W = 5,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_OUT-1:0][RATIO_W-1:0]   active,
  output logic                              busy
);
  localparam int CTRL_ADDR = NUM_OUT;
  localparam int STAT_ADDR = NUM_OUT + 1;

  logic [NUM_OUT-1:0][RATIO_W-1:0] pend;
  logic [NUM_OUT-1:0][RATIO_W-1:0] act;
  logic [NUM_OUT-1:0]              flag;
  logic [RATIO_W-1:0]              wval;
  reg_sel_e                        sel;

  assign wval   = wdata[RATIO_W-1:0];
  assign active = act;

  always_comb begin
    if (int'(addr) < NUM_OUT)        sel = SEL_RATIO;
    else if (int'(addr) == CTRL_ADDR) sel = SEL_CTRL;
    else if (int'(addr) == STAT_ADDR) sel = SEL_STATUS;
    else                              sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
      flag <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      for (int i = 0; i < NUM_OUT; i++)
        if (flag[i]) act[i] <= pend[i];
      flag <= '0;
      busy <= 1'b0;
    end else if (wr) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (sel == SEL_RATIO && int'(addr) == i) begin
          pend[i] <= wval;
          flag[i] <= (wval != act[i]);
        end
      end
      if (sel == SEL_CTRL && wdata[GO_BIT] && |flag)
        busy <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_RATIO: begin
        for (int i = 0; i < NUM_OUT; i++)
          if (int'(addr) == i) rdata[RATIO_W-1:0] = pend[i];
      end
      SEL_CTRL:   rdata[BUSY_BIT] = busy;
      SEL_STATUS: begin
        for (int i = 0; i < NUM_OUT; i++) rdata[FLAG_LSB+i] = flag[i];
      end
      default: rdata = '0;
    endcase
  end

  // R7: the hold cycle always leaves every flag clear
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (flag == '0));

  // R4: active ratios only move at the end of a hold cycle
  a_r4_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(act));

  // R9: a GO with nothing flagged never starts a hold
  a_r9_idle_go: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && flag == '0) |=> !busy);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_flag_chk
    // R3: writing back the active ratio leaves the flag clear
    a_r3_same_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy && int'(addr) == g && wval == act[g]) |=> !flag[g]);
  end
endmodule

// File: rtl/stg_divider.sv
module stg_divider #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               hold,
  output logic               en
);
  logic [RATIO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (hold)         cnt <= '0;
    else if (cnt >= ratio) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign en = !hold && (cnt == '0);

  // R11: the counter never runs past the ratio outside a hold
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (cnt <= ratio));

  // R11: for a ratio above zero an enable is never followed by another
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ratio != '0) |=> !en);
endmodule

// File: rtl/staged_clkdiv_ctrl.sv
module staged_clkdiv_ctrl #(
  parameter int NUM_OUT = 2,
  parameter int RATIO_W = 5,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] div_en
);
  logic [NUM_OUT-1:0][RATIO_W-1:0] active;
  logic                            busy;

  stg_regs #(
    .NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata), .active(active), .busy(busy)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
    stg_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .ratio(active[g]), .hold(busy), .en(div_en[g])
    );
  end

  // R5: every enable is quiet during the hold cycle
  a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (div_en == '0));

  // R6: all outputs fire together on the first cycle after the hold
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&div_en));

  // R8: the hold lasts exactly one cycle, so a GO inside it cannot extend it
  a_r8_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
endmodule

// File: tb/staged_clkdiv_ctrl_test.sv
module staged_clkdiv_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NO = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] div_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int       m_act [NO];
  int       m_pend[NO];
  bit [1:0] m_flag;
  bit       m_busy;
  int       k;

  always #(CLK_P/2) clk = ~clk;

  staged_clkdiv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_en(div_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0, 1:    return m_pend[a];
      2:       return int'(m_busy) << 1;
      default: return int'(m_flag) << 3;
    endcase
  endfunction

  function automatic int exp_en();
    int e = 0;
    if (m_busy) return 0;
    for (int i = 0; i < NO; i++)
      if (k % (m_act[i] + 1) == 0) e |= (1 << i);
    return e;
  endfunction

  task automatic model_edge(input int a, input bit w, input int d);
    if (m_busy) begin
      for (int i = 0; i < NO; i++) if (m_flag[i]) m_act[i] = m_pend[i];
      m_flag = '0;
      m_busy = 0;
      k = 0;
    end else begin
      k++;
      if (w && a < NO) begin
        m_pend[a] = d & 31;
        m_flag[a] = ((d & 31) != m_act[a]);
      end else if (w && a == 2 && (d & 1) && m_flag != 0) begin
        m_busy = 1;
      end
    end
  endtask

  task automatic cyc(input int a, input bit w, input int d, output int rd);
    bus_addr = 2'(a); bus_wr = w; bus_wdata = 8'(d);
    #1 rd = int'(bus_rdata);
    @(posedge clk);
    model_edge(a, w, d);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 R11 div_en", int'(div_en), exp_en());
  endtask

  task automatic idle(input int n);
    int rd;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, rd);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int rd;
    cyc(a, 0, 0, rd);
    check(tag, rd, exp);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rd, seed, op, o, v;
    for (int i = 0; i < NO; i++) begin m_act[i] = 0; m_pend[i] = 0; end
    m_flag = '0; m_busy = 0; k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 div_en after reset", int'(div_en), 3);

    // R1: reset values
    rd_chk("R1 ratio0", 0, 0);
    rd_chk("R1 ratio1", 1, 0);
    rd_chk("R1 ctrl", 2, 0);
    rd_chk("R1 status", 3, 0);
    idle(4);

    // R2: differing ratio sets bit 3; readback of pending value
    cyc(0, 1, 3, rd);
    rd_chk("R2 status bit3", 3, 8'h08);
    rd_chk("R2 ratio0 pending", 0, 3);
    // R3: equal value leaves flag clear
    cyc(1, 1, 0, rd);
    rd_chk("R3 equal write", 3, 8'h08);
    // R10: status is read-only, control bit 0 reads 0
    cyc(3, 1, 8'hFF, rd);
    rd_chk("R10 status ro", 3, 8'h08);
    cyc(2, 1, 8'hFC, rd);
    rd_chk("R10 ctrl go bit", 2, 0);
    // R4: pattern unchanged before GO
    idle(6);

    // R5: GO, hold cycle
    cyc(2, 1, 1, rd);
    check("R5 hold enables low", int'(div_en), 0);
    rd_chk("R5 busy in hold", 2, 8'h02);
    // R6, R7
    check("R6 all aligned", int'(div_en), 3);
    rd_chk("R7 flags clear", 3, 0);
    rd_chk("R7 busy clear", 2, 0);
    idle(12);

    // R4: ratio write mid-period does not disturb output 1
    cyc(1, 1, 2, rd);
    rd_chk("R2 status bit4", 3, 8'h10);
    idle(7);
    // R3: write-back of active value cancels the flag
    cyc(1, 1, 0, rd);
    rd_chk("R3 flag cancelled", 3, 0);
    // R9: GO with nothing flagged
    cyc(2, 1, 1, rd);
    rd_chk("R9 no busy", 2, 0);
    idle(5);

    // R8: GO and ratio write inside the hold are ignored
    cyc(1, 1, 2, rd);
    cyc(0, 1, 5, rd);
    cyc(2, 1, 1, rd);
    cyc(2, 1, 1, rd);
    rd_chk("R8 second GO ignored", 2, 0);
    idle(3);
    cyc(0, 1, 1, rd);
    cyc(2, 1, 1, rd);
    cyc(0, 1, 7, rd);
    rd_chk("R8 hold write ignored", 0, 1);
    rd_chk("R7 only flagged changed", 3, 0);
    idle(20);

    // Random mix
    seed = $urandom(32'd4242);
    for (int it = 0; it < 150; it++) begin
      op = $urandom % 6;
      o = $urandom % NO;
      case (op)
        0, 1: begin
          v = ($urandom % 3 == 0) ? m_act[o] : ($urandom % 32);
          cyc(o, 1, v, rd);
        end
        2: cyc(2, 1, $urandom % 256, rd);
        3: begin
          v = exp_rd(3);
          cyc(3, 0, 0, rd);
          check("R2 R3 random status", rd, v);
        end
        4: begin
          cyc(3, 1, $urandom % 256, rd);
          v = exp_rd(3);
          cyc(3, 0, 0, rd);
          check("R10 random status", rd, v);
        end
        default: begin
          v = exp_rd(o);
          cyc(o, 0, 0, rd);
          check("R2 random ratio", rd, v);
          idle($urandom % 8);
        end
      endcase
    end
    idle(40);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule